// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point value that has already been unpacked into fields into a signed two's-complement integer. The integer width is a parameter, normally 32 or 64 bits. The conversion always chops toward zero. The value arrives as a 3-bit class code, a sign, an unbiased signed exponent, a mantissa with an explicit leading one, and a sticky bit that stands for nonzero bits already dropped upstream.

A valid result appears two clock cycles after the input is accepted. Each result carries two flags. The invalid flag reports that the value could not be represented; in that case the output saturates according to its sign. The lost-bits flag reports that the integer dropped part of the value. A floating-point unit uses the block as the back end of its convert-to-integer operations.

Top module: `fcvt_trunc_int`

## Requirements
- R1: Class code 0 (zero) produces integer 0 with both flags clear, whatever the sign, exponent and mantissa.
- R2: A class code 1 (number) input with an exponent of INT_W or more is invalid.
- R3: A class code 1 input with an exponent below INT_W takes its magnitude as floor(in_mant × 2^(in_exp − (MANT_W−1))). The output is that magnitude, negated in two's complement when in_sign is 1.
- R4: On the R3 path, out_lost is 1 exactly when in_sticky is 1 or the truncation discards a nonzero mantissa bit. This includes negative exponents and right shifts longer than the mantissa, which give magnitude 0.
- R5: A magnitude greater than or equal to 2^(INT_W−1) + in_sign is invalid. So magnitude 2^(INT_W−1) converts without error only for a negative sign.
- R6: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are all invalid.
- R7: An invalid result sets out_invalid and clears out_lost. The output is 2^(INT_W−1)−1 + in_sign, which is the largest positive value, or the most negative value when the sign is 1.
- R8: out_valid rises exactly two cycles after in_valid. out_int, out_invalid and out_lost change only when out_valid is 1 and otherwise hold their last values. Back-to-back inputs give back-to-back results.
- R9: While rst is high, out_valid, out_int, out_invalid and out_lost are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_class | input | 3 | Class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | EXP_W | Unbiased exponent, signed |
| in_mant | input | MANT_W | Mantissa with the leading one at bit MANT_W−1 |
| in_sticky | input | 1 | Nonzero bits already dropped below the mantissa |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_int | output | INT_W | Truncated two's-complement integer |
| out_invalid | output | 1 | Value not representable; output saturated |
| out_lost | output | 1 | Nonzero bits discarded by the truncation |

## Verification
The assertions assume that a class-1 input has its mantissa normalised, with bit MANT_W−1 set. A property on that input flags any violation. They also assume the exponent is small enough that INT_W fits in its positive range. The bench forces the top mantissa bit to one on every number it drives and keeps the exponent between −32768 and 32767. It drives arbitrary mantissa contents only with the non-number classes, where the mantissa must not matter.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NUM  = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fc_class_e;

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify #(
  parameter int INT_W = 32,
  parameter int EXP_W = 16
) (
  input  logic [2:0]             class_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                   is_zero_o,
  output logic                   take_shift_o,
  output logic                   force_inv_o
);
  import fcvt_pkg::*;

  localparam logic signed [EXP_W:0] WIDTH_S = (EXP_W+1)'(INT_W);

  logic signed [EXP_W:0] exp_x;
  logic                  is_num;
  logic                  exp_big;

  always_comb begin
    exp_x        = (EXP_W+1)'(exp_i);
    is_zero_o    = (class_i == FC_ZERO);
    is_num       = (class_i == FC_NUM);
    exp_big      = (exp_x >= WIDTH_S);
    take_shift_o = is_num && !exp_big;
    // infinity, both NaNs, unused codes and oversized exponents share one path
    force_inv_o  = !is_zero_o && !take_shift_o;
  end

endmodule

// File: rtl/fcvt_align.sv
module fcvt_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 24,
  parameter int EXP_W  = 16
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic [INT_W-1:0]        mag_o,
  output logic                    lost_o
);
  localparam int DW     = EXP_W + 2 + $clog2(MANT_W + INT_W + 1);
  localparam int RW     = $clog2(MANT_W + 1);
  localparam int LW     = $clog2(INT_W + 1);
  localparam int WIDE_W = (MANT_W > INT_W) ? MANT_W : INT_W;
  localparam logic signed [DW-1:0] POINT = DW'(MANT_W - 1);
  localparam logic signed [DW-1:0] RCAP  = DW'(MANT_W);
  localparam logic signed [DW-1:0] LCAP  = DW'(INT_W);

  logic signed [DW-1:0] exp_x;
  logic signed [DW-1:0] rsh;
  logic signed [DW-1:0] lsh;
  logic [RW-1:0]        ramt;
  logic [LW-1:0]        lamt;
  logic [MANT_W-1:0]    drop_mask;
  logic [WIDE_W-1:0]    wide_m;
  logic [WIDE_W-1:0]    right_v;
  logic [WIDE_W-1:0]    left_v;

  always_comb begin
    exp_x     = DW'(exp_i);
    rsh       = POINT - exp_x;
    lsh       = exp_x - POINT;
    // shift amounts clamp: a full-width right shift already yields zero
    ramt      = (rsh > RCAP) ? RW'(MANT_W) : RW'(rsh);
    lamt      = (lsh > LCAP) ? LW'(INT_W) : LW'(lsh);
    wide_m    = WIDE_W'(mant_i);
    right_v   = wide_m >> ramt;
    left_v    = wide_m << lamt;
    drop_mask = ~({MANT_W{1'b1}} << ramt);
    if (rsh >= 0) begin
      mag_o  = INT_W'(right_v);
      lost_o = sticky_i | (|(mant_i & drop_mask));
    end else begin
      mag_o  = INT_W'(left_v);
      lost_o = sticky_i;
    end
  end

endmodule

// File: rtl/fcvt_saturate.sv
module fcvt_saturate #(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             force_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o
);
  localparam logic [INT_W:0]   HALF   = (INT_W+1)'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] MAXPOS = {1'b0, {(INT_W-1){1'b1}}};

  logic [INT_W:0] limit;

  always_comb begin
    // negative side reaches one step further than the positive side
    limit     = HALF + (INT_W+1)'(sign_i);
    invalid_o = force_i | ({1'b0, mag_i} >= limit);
    if (invalid_o)
      res_o = MAXPOS + INT_W'(sign_i);
    else if (sign_i)
      res_o = ~mag_i + INT_W'(1);
    else
      res_o = mag_i;
  end

endmodule

// File: rtl/fcvt_trunc_int.sv
module fcvt_trunc_int #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 24,
  parameter int EXP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  output logic                    out_valid,
  output logic [INT_W-1:0]        out_int,
  output logic                    out_invalid,
  output logic                    out_lost
);

  // stage 0 combinational: classify and align
  logic             c_zero;
  logic             c_shift;
  logic             c_force;
  logic [INT_W-1:0] a_mag;
  logic             a_lost;

  fcvt_classify #(.INT_W(INT_W), .EXP_W(EXP_W)) u_classify (
    .class_i     (in_class),
    .exp_i       (in_exp),
    .is_zero_o   (c_zero),
    .take_shift_o(c_shift),
    .force_inv_o (c_force)
  );

  fcvt_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i   (in_exp),
    .mant_i  (in_mant),
    .sticky_i(in_sticky),
    .mag_o   (a_mag),
    .lost_o  (a_lost)
  );

  // stage 1 registers
  logic             s1_valid;
  logic             s1_sign;
  logic             s1_force;
  logic             s1_lost;
  logic [INT_W-1:0] s1_mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_force <= 1'b0;
      s1_lost  <= 1'b0;
      s1_mag   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign  <= in_sign;
        s1_force <= c_force;
        s1_lost  <= c_shift & a_lost;
        s1_mag   <= c_shift ? a_mag : '0;
      end
    end
  end

  // stage 1 combinational: range check and sign
  logic [INT_W-1:0] r_int;
  logic             r_inv;

  fcvt_saturate #(.INT_W(INT_W)) u_saturate (
    .sign_i   (s1_sign),
    .mag_i    (s1_mag),
    .force_i  (s1_force),
    .res_o    (r_int),
    .invalid_o(r_inv)
  );

  // stage 2 output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_lost    <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_int     <= r_int;
        out_invalid <= r_inv;
        out_lost    <= s1_lost & ~r_inv;
      end
    end
  end

  logic unused_zero;
  assign unused_zero = c_zero;

endmodule

// File: rtl/fcvt_trunc_int_chk.sv
module fcvt_trunc_int_chk #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 24,
  parameter int EXP_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [2:0]              in_class,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [MANT_W-1:0]       in_mant,
  input logic                    in_sticky,
  input logic                    out_valid,
  input logic [INT_W-1:0]        out_int,
  input logic                    out_invalid,
  input logic                    out_lost
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [EXP_W:0] WIDTH_S = (EXP_W+1)'(INT_W);

  logic unused_in;
  assign unused_in = in_sign ^ in_sticky;

  // input precondition: numbers arrive normalised
  p_norm_input_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd1) |-> in_mant[MANT_W-1]);

  p_zero_class_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd0) |-> ##2
    (out_int == '0 && !out_invalid && !out_lost));

  p_big_exp_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd1 && (EXP_W+1)'(in_exp) >= WIDTH_S) |-> ##2 out_invalid);

  p_non_number_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class >= 3'd2) |-> ##2 out_invalid);

  p_sat_value_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> ((out_int == POS_SAT || out_int == NEG_SAT) && !out_lost));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_int) && $stable(out_invalid) && $stable(out_lost)));

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_int == '0 && !out_invalid && !out_lost));

endmodule

bind fcvt_trunc_int fcvt_trunc_int_chk #(
  .INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
  .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
  .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
  .out_lost(out_lost)
);

// File: tb/test_fcvt_trunc_int.sv
`timescale 1ns/1ps
module test_fcvt_trunc_int;
  localparam int W = 32;
  localparam int M = 24;
  localparam int E = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst;
  logic                in_valid;
  logic [2:0]          in_class;
  logic                in_sign;
  logic signed [E-1:0] in_exp;
  logic [M-1:0]        in_mant;
  logic                in_sticky;
  logic                out_valid;
  logic [W-1:0]        out_int;
  logic                out_invalid;
  logic                out_lost;

  fcvt_trunc_int #(.INT_W(W), .MANT_W(M), .EXP_W(E)) i_fcvt_trunc_int (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_lost(out_lost)
  );

  typedef struct {
    bit           v;
    logic [W-1:0] val;
    bit           inv;
    bit           lost;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int           checks = 0;
  int           fails  = 0;
  logic [W-1:0] h_val  = '0;
  bit           h_inv  = 1'b0;
  bit           h_lost = 1'b0;
  bit           done   = 1'b0;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // behavioural reference following the requirements
  function automatic exp_t model(bit v, logic [2:0] c, bit s, int e, logic [M-1:0] m, bit st);
    exp_t            r;
    longint unsigned mag;
    longint unsigned lim;
    bit              lost;
    int              rs;
    r.v = v; r.val = '0; r.inv = 0; r.lost = 0; r.tag = "R8";
    if (!v) return r;
    if (c == 3'd0) begin
      r.tag = "R1";
      return r;
    end
    if (c != 3'd1 || e >= W) begin
      r.inv  = 1;
      r.val  = s ? 32'h8000_0000 : 32'h7fff_ffff;
      r.tag  = (c != 3'd1) ? "R6 R7" : "R2 R7";
      return r;
    end
    rs = (M - 1) - e;
    if (rs <= 0) begin
      mag  = longint'(m) << (-rs);
      lost = st;
    end else if (rs >= 60) begin
      mag  = 0;
      lost = st || (m != 0);
    end else begin
      mag  = longint'(m) >> rs;
      lost = st || ((mag << rs) != longint'(m));
    end
    lim = 64'h8000_0000 + longint'(s);
    if (mag >= lim) begin
      r.inv = 1;
      r.val = s ? 32'h8000_0000 : 32'h7fff_ffff;
      r.tag = "R5 R7";
    end else begin
      r.val  = s ? W'(-mag) : W'(mag);
      r.lost = lost;
      r.tag  = lost ? "R4" : ((mag == 64'h8000_0000) ? "R5" : "R3");
    end
    return r;
  endfunction

  task automatic compare(exp_t x);
    chk(x.tag, "out_valid", longint'(out_valid), longint'(x.v));
    if (x.v) begin
      h_val = x.val; h_inv = x.inv; h_lost = x.lost;
    end
    chk(x.v ? x.tag : "R8", "out_int", longint'(out_int), longint'(h_val));
    chk(x.v ? x.tag : "R8", "out_invalid", longint'(out_invalid), longint'(h_inv));
    chk(x.v ? x.tag : "R8", "out_lost", longint'(out_lost), longint'(h_lost));
  endtask

  task automatic cyc(bit v, logic [2:0] c, bit s, int e, logic [M-1:0] m, bit st);
    @(negedge clk);
    if (q.size() == 2) compare(q.pop_front());
    in_valid  = v;
    in_class  = c;
    in_sign   = s;
    in_exp    = E'(e);
    in_mant   = m;
    in_sticky = st;
    q.push_back(model(v, c, s, e, m, st));
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_class = 0; in_sign = 0;
    in_exp = '0; in_mant = '0; in_sticky = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid", longint'(out_valid), 0);
    chk("R9", "out_int", longint'(out_int), 0);
    chk("R9", "out_invalid", longint'(out_invalid), 0);
    chk("R9", "out_lost", longint'(out_lost), 0);
    rst = 1'b0;

    // R1: zero class ignores sign and junk fields
    cyc(1, 3'd0, 1, 40, 24'hABCDEF, 1);
    // R3: plain values
    cyc(1, 3'd1, 0, 0, 24'h800000, 0);
    cyc(1, 3'd1, 0, 30, 24'hFFFFFF, 0);
    cyc(1, 3'd1, 1, 23, 24'hFFFFFF, 0);
    // R4: lost bits, negative exponents, long shifts
    cyc(1, 3'd1, 1, 0, 24'hC00000, 0);
    cyc(1, 3'd1, 0, -1, 24'h800000, 0);
    cyc(1, 3'd1, 1, -32768, 24'h800000, 0);
    cyc(1, 3'd1, 0, 23, 24'hFFFFFF, 1);
    cyc(0, 3'd0, 0, 0, 24'h0, 0);
    // R5: the asymmetric boundary
    cyc(1, 3'd1, 1, 31, 24'h800000, 0);
    cyc(1, 3'd1, 0, 31, 24'h800000, 0);
    cyc(1, 3'd1, 1, 31, 24'h800001, 0);
    cyc(1, 3'd1, 1, 31, 24'h800000, 1);
    // R2: exponent at or above the width
    cyc(1, 3'd1, 0, 32, 24'h800000, 0);
    cyc(1, 3'd1, 1, 32767, 24'hFFFFFF, 1);
    // R6: non-numbers and unused codes
    cyc(1, 3'd2, 0, 0, 24'h0, 0);
    cyc(1, 3'd3, 1, 5, 24'h123456, 1);
    cyc(1, 3'd4, 0, -3, 24'h000001, 0);
    cyc(1, 3'd7, 1, 1, 24'h800000, 0);
    // R8: bubbles then more
    cyc(0, 3'd1, 0, 3, 24'h800000, 0);
    cyc(0, 3'd2, 1, 3, 24'h800000, 0);

    for (int i = 0; i < 600; i++) begin
      bit         v  = ($urandom % 4) != 0;
      int         pk = $urandom % 16;
      logic [2:0] c  = (pk < 12) ? 3'd1 : 3'(pk % 8);
      int         e  = int'($urandom % 48) - 10;
      logic [M-1:0] m = {1'b1, 23'($urandom)};
      if (c != 3'd1) m = 24'($urandom);
      cyc(v, c, 1'($urandom), e, m, 1'($urandom));
    end

    cyc(0, 3'd0, 0, 0, 24'h0, 0);
    cyc(0, 3'd0, 0, 0, 24'h0, 0);
    @(negedge clk);
    while (q.size() > 0) begin
      compare(q.pop_front());
      @(negedge clk);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule